// File: doc/BRIEF.md
# Split-Access 64-bit Counter Register Bank

This block is a bank of 64-bit registers placed behind a 32-bit memory-mapped port. Each register occupies two adjacent 32-bit words. Register slot 0 holds the master configuration value. Slots 1 to 7 hold free-running counters. Slots 8 to 15 are unmapped. Counters 0 to 2 (slots 1 to 3) count events: requests dequeued, outbound encrypt requests and inbound decrypt requests. Counters 3 to 6 (slots 4 to 7) count bytes: outbound bytes encrypted, outbound bytes protected, inbound bytes decrypted and inbound bytes validated. An engine elsewhere on the chip pulses a per-counter strobe and, for the byte counters, presents a byte count alongside it.

A 64-bit write is done as two 32-bit bus writes. The write to the lower-address word is only staged. The write to the higher-address word combines with the staged half and updates all 64 bits in one cycle. A 64-bit read is also done as two bus reads. Reading the half that holds bits 63:32 freezes bits 31:0 of the same register in a snapshot, so the second read returns a value from the same instant even if the counter has moved. Two static configuration inputs select the bus format: one byte-reverses every 32-bit bus word, and the other reverses which address holds which half.

Three small state machines control the block:
- Write staging has two states. WS_IDLE moves to WS_STAGED on a lower-address write. WS_STAGED returns to WS_IDLE on a higher-address commit or a software reset.
- Read snapshot has two states. RS_LIVE moves to RS_HELD on a read of bits 63:32. RS_HELD returns to RS_LIVE on a read of bits 31:0 or a software reset. RS_HELD stays in RS_HELD, with a fresh capture, on another read of bits 63:32.
- Software reset has two states. SR_RUN moves to SR_CLEAR when a commit to slot 0 carries bit 31 set. SR_CLEAR always returns to SR_RUN on the next cycle.

Top module: `ctr_bank`

## Requirements
- R1: The word address `bus_addr` selects slot `bus_addr[6:3]` and half `bus_addr[2]`. With `cfg_word_swap`=0, half 0 (the lower address) carries bits 63:32 and half 1 carries bits 31:0.
- R2: A write to half 0 of a mapped slot only stages the word. The slot's contents, and `mcfg_o` for slot 0, do not change until the commit.
- R3: A write to half 1 of a mapped slot commits all 64 bits in that clock edge. The committed value combines the bus word with the staged word. If nothing has been staged since the last commit or software reset, the other half is written as zero.
- R4: A read of the half holding bits 63:32 captures bits 31:0 of that slot. The next read of bits 31:0 of the same slot returns the captured value and releases the snapshot. A read of bits 31:0 with no snapshot held returns the live value.
- R5: Strobe `evt_strobe[i]` increments counter i, which sits in slot i+1. Counters 0 to 2 add exactly 1 and ignore their byte-count field. Counters 3 to 6 add the 16-bit field `evt_bytes[16*i+15:16*i]`.
- R6: Counters wrap modulo 2^64, and a carry propagates from bit 31 into bit 32.
- R7: When a committed write and an increment strobe reach the same counter in the same cycle, the written value is kept and the increment is lost.
- R8: A commit to slot 0 with bit 31 set stores the other 63 bits in `mcfg_o` with bit 31 read back as 0. `soft_rst_o` is high for exactly the one cycle after the commit. At the end of that cycle all counters, the staging state and the snapshot are cleared.
- R9: With `cfg_le`=1, each 32-bit word is byte-reversed on the way in and on the way out. Bus byte 0 (bits 7:0) maps to internal bits 31:24.
- R10: With `cfg_word_swap`=1, half 0 carries bits 31:0 and half 1 carries bits 63:32. Staging still happens on half 0 and the commit still happens on half 1.
- R11: A write to an unmapped slot (8 to 15) has no effect, and it does not disturb the staged word. A read of an unmapped slot returns zero.
- R12: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read request. `bus_rvalid` is low when no read was requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_le | input | 1 | Byte-reverse each bus word |
| cfg_word_swap | input | 1 | Lower address carries bits 31:0 |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address: slot in bits 6:3, half in bit 2 |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, registered |
| bus_rvalid | output | 1 | Read data valid |
| evt_strobe | input | 7 | Per-counter increment strobe |
| evt_bytes | input | 112 | Per-counter 16-bit byte count, counter i at bits 16*i+15:16*i |
| mcfg_o | output | 64 | Master configuration value |
| soft_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The assertions assume that `cfg_le` and `cfg_word_swap` change only while no write is staged and no snapshot is held. They also assume that the bus makes at most one access per cycle. The bench changes the two format inputs only between complete 64-bit transfers. It also leaves an idle cycle after a software-reset commit, so the clear cycle never overlaps a bus access. Same-cycle collisions, meaning an increment racing a commit and a count moving between two reads, are created deliberately. Every other strobe is kept apart from bus traffic, so the expected counter values can be computed by simple arithmetic.

// File: rtl/ctr_bank_pkg.sv
package ctr_bank_pkg;
    typedef enum logic {WS_IDLE, WS_STAGED} wstage_e;
    typedef enum logic {RS_LIVE, RS_HELD}   rsnap_e;
    typedef enum logic {SR_RUN, SR_CLEAR}   srst_e;

    localparam int unsigned SRST_BIT = 31;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/ctr_bank_counter.sv
module ctr_bank_counter #(
    parameter int CW        = 64,
    parameter int AMT_W     = 16,
    parameter int BYTE_MODE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_val,
    input  logic             inc,
    input  logic [AMT_W-1:0] amount,
    output logic [CW-1:0]    q
);
    logic [CW-1:0] step;
    assign step = (BYTE_MODE != 0) ? CW'(amount) : CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (wr_en) q <= wr_val;
        else if (inc)   q <= q + step;
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !clr |=> q == $past(wr_val)); // R7
    AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !wr_en && !clr |=> q == $past(q) + $past(step)); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0); // R8
endmodule

// File: rtl/ctr_bank_wstage.sv
module ctr_bank_wstage
    import ctr_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        stage_en,
    input  logic        commit_en,
    input  logic        word_swap,
    input  logic [31:0] wdata,
    output logic [63:0] commit_val
);
    wstage_e     state, state_nx;
    logic [31:0] staged;
    logic [31:0] other;

    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE:   if (stage_en) state_nx = WS_STAGED;
            WS_STAGED: if (commit_en) state_nx = WS_IDLE;
            default:   state_nx = WS_IDLE;
        endcase
        if (clr) state_nx = WS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        staged <= '0;
        else if (stage_en) staged <= wdata;
    end

    assign other      = (state == WS_STAGED) ? staged : 32'h0;
    assign commit_val = word_swap ? {wdata, other} : {other, wdata};

    AST_STAGE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en && !clr |=> state == WS_STAGED); // R2
    AST_COMMIT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en && !stage_en |=> state == WS_IDLE); // R3
endmodule

// File: rtl/ctr_bank_rsnap.sv
module ctr_bank_rsnap
    import ctr_bank_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rd_upper,
    input  logic          rd_lower,
    input  logic [IW-1:0] idx,
    input  logic [63:0]   live,
    output logic [31:0]   word
);
    rsnap_e        state, state_nx;
    logic [31:0]   snap;
    logic [IW-1:0] snap_idx;

    always_comb begin
        state_nx = state;
        unique case (state)
            RS_LIVE: if (rd_upper) state_nx = RS_HELD;
            RS_HELD: if (rd_lower) state_nx = RS_LIVE;
            default: state_nx = RS_LIVE;
        endcase
        if (clr) state_nx = RS_LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_LIVE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap     <= '0;
            snap_idx <= '0;
        end else if (rd_upper) begin
            snap     <= live[31:0];
            snap_idx <= idx;
        end
    end

    always_comb begin
        if (rd_upper)                                word = live[63:32];
        else if (state == RS_HELD && snap_idx == idx) word = snap;
        else                                         word = live[31:0];
    end

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_upper && !clr |=> state == RS_HELD); // R4
    AST_SNAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lower && !clr |=> state == RS_LIVE); // R4
endmodule

// File: rtl/ctr_bank.sv
module ctr_bank
    import ctr_bank_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int NUM_CTR = 7,
    parameter int NUM_EVT = 3,
    parameter int BYTES_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_le,
    input  logic                       cfg_word_swap,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:2]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       bus_rvalid,
    input  logic [NUM_CTR-1:0]         evt_strobe,
    input  logic [NUM_CTR*BYTES_W-1:0] evt_bytes,
    output logic [63:0]                mcfg_o,
    output logic                       soft_rst_o
);
    localparam int IW       = ADDR_W - 3;
    localparam int NUM_SLOT = 1 << IW;
    localparam int NUM_REGS = NUM_CTR + 1;

    logic [IW-1:0] idx;
    logic          half_hi, mapped, acc_wr, acc_rd;
    logic          stage_en, commit_en, upper_sel, rd_upper, rd_lower;
    logic [31:0]   wword, rword;
    logic [63:0]   commit_val, live, mcfg_q;
    logic [63:0]   regval [NUM_SLOT];
    logic          srst_go, clr;
    srst_e         srst_state, srst_nx;

    assign idx       = bus_addr[ADDR_W-1:3];
    assign half_hi   = bus_addr[2];
    assign mapped    = (32'(idx) < NUM_REGS);
    assign acc_wr    = bus_valid && bus_write && mapped;
    assign acc_rd    = bus_valid && !bus_write;
    assign wword     = cfg_le ? swap_bytes(bus_wdata) : bus_wdata;
    assign stage_en  = acc_wr && !half_hi;
    assign commit_en = acc_wr && half_hi;
    assign upper_sel = (half_hi == cfg_word_swap);
    assign rd_upper  = acc_rd && mapped && upper_sel;
    assign rd_lower  = acc_rd && mapped && !upper_sel;

    ctr_bank_wstage u_wstage (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .stage_en(stage_en), .commit_en(commit_en),
        .word_swap(cfg_word_swap), .wdata(wword), .commit_val(commit_val)
    );

    // software reset sequencing
    assign srst_go = commit_en && (idx == '0) && commit_val[SRST_BIT];

    always_comb begin
        srst_nx = srst_state;
        unique case (srst_state)
            SR_RUN:   if (srst_go) srst_nx = SR_CLEAR;
            SR_CLEAR: srst_nx = SR_RUN;
            default:  srst_nx = SR_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) srst_state <= SR_RUN;
        else        srst_state <= srst_nx;
    end

    assign soft_rst_o = (srst_state == SR_CLEAR);
    assign clr        = soft_rst_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mcfg_q <= '0;
        else if (commit_en && idx == '0)
            mcfg_q <= commit_val & ~(64'd1 << SRST_BIT);
    end
    assign mcfg_o = mcfg_q;

    assign regval[0] = mcfg_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
            logic [63:0] q;
            ctr_bank_counter #(
                .CW(64), .AMT_W(BYTES_W), .BYTE_MODE((gi >= NUM_EVT) ? 1 : 0)
            ) u_ctr (
                .clk(clk), .rst_n(rst_n), .clr(clr),
                .wr_en(commit_en && (32'(idx) == gi + 1)),
                .wr_val(commit_val),
                .inc(evt_strobe[gi]),
                .amount(evt_bytes[gi*BYTES_W +: BYTES_W]),
                .q(q)
            );
            assign regval[gi+1] = q;
        end
        for (gi = NUM_REGS; gi < NUM_SLOT; gi++) begin : g_hole
            assign regval[gi] = 64'h0;
        end
    endgenerate

    assign live = regval[idx];

    ctr_bank_rsnap #(.IW(IW)) u_rsnap (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .rd_upper(rd_upper), .rd_lower(rd_lower),
        .idx(idx), .live(live), .word(rword)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= acc_rd;
            if (acc_rd && mapped) bus_rdata <= cfg_le ? swap_bytes(rword) : rword;
            else                  bus_rdata <= '0;
        end
    end

    AST_STAGE_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en |=> $stable(mcfg_o)); // R2
    AST_SRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_go |=> soft_rst_o); // R8
    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o); // R8
    AST_CFG_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en && idx == '0 |=> !mcfg_o[SRST_BIT]); // R8
    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> bus_rvalid); // R12
    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && !mapped |=> bus_rdata == 32'h0); // R11
endmodule

// File: tb/ctr_bank_bench.sv
module ctr_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_le = 1'b0, cfg_word_swap = 1'b0;
    logic         bus_valid = 1'b0, bus_write = 1'b0;
    logic [6:2]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid;
    logic [6:0]   evt_strobe = '0;
    logic [111:0] evt_bytes = '0;
    logic [63:0]  mcfg_o;
    logic         soft_rst_o;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    ctr_bank u_ctr_bank (
        .clk(clk), .rst_n(rst_n), .cfg_le(cfg_le), .cfg_word_swap(cfg_word_swap),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .evt_strobe(evt_strobe), .evt_bytes(evt_bytes),
        .mcfg_o(mcfg_o), .soft_rst_o(soft_rst_o)
    );

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] slot, input logic half, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = {slot, half}; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] slot, input logic half, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {slot, half};
        @(negedge clk);
        d = bus_rdata;
        chk("R12 rvalid after read", 64'(bus_rvalid), 64'd1);
        bus_valid = 1'b0;
    endtask

    // half index that holds bits 63:32 under the current word order
    function automatic logic up_half();
        return cfg_word_swap;
    endfunction

    task automatic wr64(input logic [3:0] slot, input logic [63:0] v);
        logic [31:0] w0, w1;
        w0 = cfg_word_swap ? v[31:0] : v[63:32];
        w1 = cfg_word_swap ? v[63:32] : v[31:0];
        if (cfg_le) begin w0 = bsw(w0); w1 = bsw(w1); end
        bus_wr(slot, 1'b0, w0);
        bus_wr(slot, 1'b1, w1);
    endtask

    task automatic rd64(input logic [3:0] slot, output logic [63:0] v);
        logic [31:0] hi, lo;
        bus_rd(slot, up_half(), hi);
        bus_rd(slot, ~up_half(), lo);
        if (cfg_le) begin hi = bsw(hi); lo = bsw(lo); end
        v = {hi, lo};
    endtask

    task automatic pulse(input int ctr, input logic [15:0] amt);
        @(negedge clk);
        evt_strobe[ctr] = 1'b1; evt_bytes[ctr*16 +: 16] = amt;
        @(negedge clk);
        evt_strobe = '0; evt_bytes = '0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R12 rvalid idle", 64'(bus_rvalid), 64'd0);
        chk("R8 mcfg reset", mcfg_o, 64'd0);
        chk("R8 srst idle", 64'(soft_rst_o), 64'd0);
        rd64(4'd1, v);
        chk("R5 counter reset", v, 64'd0);
    endtask

    task automatic t_order();
        logic [31:0] w;
        logic [63:0] v;
        bus_wr(4'd1, 1'b0, 32'h11223344);
        bus_wr(4'd1, 1'b1, 32'h55667788);
        bus_rd(4'd1, 1'b0, w);
        chk("R1 lower addr high bits", 64'(w), 64'h11223344);
        bus_rd(4'd1, 1'b1, w);
        chk("R1 higher addr low bits", 64'(w), 64'h55667788);
        wr64(4'd0, 64'h0000_00C3_0000_0101);
        chk("R3 mcfg commit", mcfg_o, 64'h0000_00C3_0000_0101);
    endtask

    task automatic t_stage();
        logic [63:0] v;
        bus_wr(4'd2, 1'b0, 32'hAAAA0000);
        rd64(4'd2, v);
        chk("R2 staged not visible", v, 64'd0);
        bus_wr(4'd0, 1'b0, 32'h12345678);
        chk("R2 mcfg unchanged by stage", mcfg_o, 64'h0000_00C3_0000_0101);
        bus_wr(4'd0, 1'b1, 32'h0000_0007);
        chk("R3 combined commit", mcfg_o, 64'h12345678_00000007);
        bus_wr(4'd2, 1'b0, 32'hAAAA0000);
        bus_wr(4'd2, 1'b1, 32'h00000001);
        rd64(4'd2, v);
        chk("R3 combined counter", v, 64'hAAAA0000_00000001);
        wr64(4'd3, 64'h5_0000_0006);
        bus_wr(4'd3, 1'b1, 32'h80);
        rd64(4'd3, v);
        chk("R3 unstaged half zero", v, 64'h80);
    endtask

    task automatic t_incr();
        logic [63:0] v;
        pulse(0, 16'd100); pulse(0, 16'd100); pulse(0, 16'd100);
        rd64(4'd1, v);
        chk("R5 event counter +1 each", v, 64'h11223344_5566778B);
        pulse(3, 16'd100); pulse(3, 16'h0FFF);
        rd64(4'd4, v);
        chk("R5 byte counter adds count", v, 64'h1063);
        rd64(4'd5, v);
        chk("R5 neighbour untouched", v, 64'd0);
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        wr64(4'd5, 64'hFFFFFFFF_FFFFFFF0);
        pulse(4, 16'h20);
        rd64(4'd5, v);
        chk("R6 wrap mod 2^64", v, 64'h10);
        wr64(4'd6, 64'h00000000_FFFFFFFF);
        pulse(5, 16'd1);
        rd64(4'd6, v);
        chk("R6 carry into upper word", v, 64'h1_00000000);
    endtask

    task automatic t_collide();
        logic [63:0] v;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = {4'd7, 1'b1}; bus_wdata = 32'h42;
        evt_strobe[6] = 1'b1; evt_bytes[96 +: 16] = 16'd5;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; evt_strobe = '0; evt_bytes = '0;
        rd64(4'd7, v);
        chk("R7 write wins over increment", v, 64'h42);
        pulse(6, 16'd5);
        rd64(4'd7, v);
        chk("R7 increment after write", v, 64'h47);
    endtask

    task automatic t_snap();
        logic [31:0] w;
        bus_rd(4'd4, 1'b0, w);
        chk("R4 upper read", 64'(w), 64'h0);
        pulse(3, 16'hFFFF);
        bus_rd(4'd4, 1'b1, w);
        chk("R4 snapshot low half", 64'(w), 64'h1063);
        bus_rd(4'd4, 1'b1, w);
        chk("R4 live low after release", 64'(w), 64'h00011062);
        bus_rd(4'd4, 1'b0, w);
        chk("R4 live upper", 64'(w), 64'h0);
    endtask

    task automatic t_wswap();
        logic [31:0] w;
        logic [63:0] v;
        cfg_word_swap = 1'b1;
        bus_wr(4'd2, 1'b0, 32'hCAFEF00D);
        rd64(4'd2, v);
        chk("R10 stage on lower addr", v, 64'hAAAA0000_00000001);
        bus_wr(4'd2, 1'b1, 32'h0BADBEEF);
        bus_rd(4'd2, 1'b1, w);
        chk("R10 higher addr high bits", 64'(w), 64'h0BADBEEF);
        bus_rd(4'd2, 1'b0, w);
        chk("R10 lower addr low bits", 64'(w), 64'hCAFEF00D);
        cfg_word_swap = 1'b0;
        bus_rd(4'd2, 1'b0, w);
        chk("R10 default order restored", 64'(w), 64'h0BADBEEF);
        bus_rd(4'd2, 1'b1, w);
    endtask

    task automatic t_le();
        logic [31:0] w;
        logic [63:0] v;
        cfg_le = 1'b1;
        wr64(4'd6, 64'h01020304_05060708);
        rd64(4'd6, v);
        chk("R9 round trip", v, 64'h01020304_05060708);
        bus_rd(4'd6, 1'b0, w);
        chk("R9 bus word swapped", 64'(w), 64'h04030201);
        bus_rd(4'd6, 1'b1, w);
        cfg_le = 1'b0;
        bus_rd(4'd6, 1'b0, w);
        chk("R9 internal order", 64'(w), 64'h01020304);
        bus_rd(4'd6, 1'b1, w);
    endtask

    task automatic t_hole();
        logic [31:0] w;
        logic [63:0] v;
        bus_wr(4'd1, 1'b0, 32'h77);
        bus_wr(4'd9, 1'b0, 32'h99);
        bus_wr(4'd9, 1'b1, 32'h98);
        bus_wr(4'd1, 1'b1, 32'h1);
        rd64(4'd1, v);
        chk("R11 unmapped write ignored", v, 64'h77_00000001);
        bus_rd(4'd9, 1'b0, w);
        chk("R11 unmapped read zero", 64'(w), 64'h0);
        bus_rd(4'd15, 1'b1, w);
        chk("R11 unmapped read zero top", 64'(w), 64'h0);
    endtask

    task automatic t_srst();
        logic [63:0] v;
        bus_wr(4'd0, 1'b0, 32'h000000A5);
        bus_wr(4'd0, 1'b1, 32'h80000012);
        chk("R8 pulse after commit", 64'(soft_rst_o), 64'd1);
        @(negedge clk);
        chk("R8 pulse one cycle", 64'(soft_rst_o), 64'd0);
        chk("R8 reset bit reads 0", mcfg_o, 64'h000000A5_00000012);
        rd64(4'd1, v); chk("R8 counter1 cleared", v, 64'd0);
        rd64(4'd4, v); chk("R8 counter4 cleared", v, 64'd0);
        rd64(4'd7, v); chk("R8 counter7 cleared", v, 64'd0);
        rd64(4'd0, v); chk("R8 mcfg readback", v, 64'h000000A5_00000012);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_stage();
        t_incr();
        t_wrap();
        t_collide();
        t_snap();
        t_wswap();
        t_le();
        t_hole();
        t_srst();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule